// File: doc/BRIEF.md
# Virtual Address Translation and Byte Cache Probe

This block takes a 14-bit virtual address and returns one data byte with a report on each lookup stage. The virtual page number is first looked up in a small set-associative translation buffer. On a miss it falls back to a page table indexed directly by the page number, and an invalid page-table entry is reported as a page fault. A valid translation forms a 12-bit physical address, which then probes a direct-mapped cache of 4-byte lines. The response carries the translation-buffer hit flag, the fault flag, the physical address, the cache hit flag and the selected byte.

Requests enter over a valid/ready handshake and responses leave over a valid/ready handshake. Only one request is in flight at a time. `req_ready` is high only while the block is idle. A response stays on the output, unchanged, until `rsp_ready` accepts it, so a slow consumer stalls new requests. The translation buffer, the page table and the cache are loaded through a plain one-cycle write port. That port is never used in the same cycle as a lookup. A miss never refills the translation buffer or the cache.

Top module: `addr_xlate_probe`

## Requirements
- R1: The virtual page number is `vaddr[13:6]`. The buffer set is `vpn[1:0]` and the buffer tag is `vpn[7:2]`. A valid way in that set whose tag matches gives `rsp_tlb_hit`=1 and `rsp_paddr` = {way PPN, `vaddr[5:0]`}. If more than one way matches, the lowest way is used.
- R2: On a buffer miss, a valid page-table entry at index `vpn` gives `rsp_tlb_hit`=0, `rsp_fault`=0 and `rsp_paddr` = {entry PPN, `vaddr[5:0]`}.
- R3: On a buffer miss with an invalid page-table entry, the response has `rsp_fault`=1, `rsp_tlb_hit`=0, `rsp_cache_hit`=0, `rsp_paddr`=0 and `rsp_byte`=0. A buffer hit never faults.
- R4: The cache line index is `paddr[5:2]`, the tag is `paddr[11:6]` and the byte offset is `paddr[1:0]`. A hit needs a valid line with an equal tag. It returns byte lane `offset`, where lane 0 is line data bits [7:0].
- R5: A cache miss (invalid line or tag mismatch) gives `rsp_cache_hit`=0 and `rsp_byte`=0.
- R6: Take the clock edge that accepts a request. `rsp_valid` goes high on the next edge after it on a buffer hit, and on the second edge after it on a buffer miss.
- R7: `req_ready` is high only when no request is in flight. While `rsp_valid` is high and `rsp_ready` is low, every response output holds its value.
- R8: A buffer miss does not refill the buffer, so the same address misses again.
- R9: Reset clears every valid bit in all three stores, drives `rsp_valid` low and `req_ready` high.
- R10: A config write with `cfg_en`=1 stores one entry, selected by `cfg_kind`. Kind 0 writes a buffer way: set `cfg_addr[3:2]`, way `cfg_addr[1:0]`, tag `cfg_tag`, PPN `cfg_data[5:0]`. Kind 1 writes page-table entry `cfg_addr[7:0]` with PPN `cfg_data[5:0]`. Kind 2 writes cache line `cfg_addr[3:0]` with tag `cfg_tag` and data `cfg_data`. Every kind sets the valid bit from `cfg_valid`. Kind 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_vaddr | input | 14 | Virtual address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes response |
| rsp_tlb_hit | output | 1 | Translation buffer hit |
| rsp_fault | output | 1 | Page fault |
| rsp_paddr | output | 12 | Physical address (0 on fault) |
| rsp_cache_hit | output | 1 | Cache hit |
| rsp_byte | output | 8 | Data byte (0 on miss or fault) |
| cfg_en | input | 1 | Config write strobe |
| cfg_kind | input | 2 | Target store: 0 buffer, 1 page table, 2 cache, 3 none |
| cfg_addr | input | 8 | Entry select |
| cfg_valid | input | 1 | Valid bit written |
| cfg_tag | input | 6 | Buffer or cache tag |
| cfg_data | input | 32 | PPN in [5:0], or cache line data |

## Verification
The assertions check the handshake on every cycle. They confirm that ready and response-valid never overlap, that a stalled response holds all its fields, and that no response appears on the edge right after acceptance. They also check that every faulting or missing response has zeroed address, hit and byte fields. Only the bench scenarios can show the address arithmetic: set and tag selection, page-table fallback, cache index, tag and byte-lane choice. The same holds for the exact hit and miss latency, the absence of refill on repeated misses, and the effect or no-effect of each config kind. The bench checks these against its own model of the three stores.

// File: rtl/addr_xlate_pkg.sv
package addr_xlate_pkg;
  typedef enum logic [1:0] {
    CFG_TLB  = 2'd0,
    CFG_PT   = 2'd1,
    CFG_LINE = 2'd2,
    CFG_NONE = 2'd3
  } cfg_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WALK = 2'd2,
    ST_RESP = 2'd3
  } xl_state_e;
endpackage

// File: rtl/xl_tlb_array.sv
module xl_tlb_array #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  parameter int PPN_W = 6,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic             wr_valid,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn
);
  logic [WAYS-1:0]  vld_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][WAYS];
  logic [WAYS-1:0]  match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (wr_en) begin
      vld_q[wr_set][wr_way] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way] <= wr_tag;
      ppn_q[wr_set][wr_way] <= wr_ppn;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  // lowest matching way wins
  always_comb begin
    lk_ppn = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) lk_ppn = ppn_q[lk_set][w];
    end
  end
  assign lk_hit = |match;
endmodule

// File: rtl/xl_page_table.sv
module xl_page_table #(
  parameter int VPN_W = 8,
  parameter int PPN_W = 6,
  localparam int ENTRIES = 1 << VPN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic             wr_valid,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [VPN_W-1:0] rd_vpn,
  output logic             rd_valid,
  output logic [PPN_W-1:0] rd_ppn
);
  logic [ENTRIES-1:0] vld_q;
  logic [PPN_W-1:0]   ppn_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n)     vld_q <= '0;
    else if (wr_en) vld_q[wr_vpn] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) ppn_q[wr_vpn] <= wr_ppn;
  end

  assign rd_valid = vld_q[rd_vpn];
  assign rd_ppn   = ppn_q[rd_vpn];
endmodule

// File: rtl/xl_byte_cache.sv
module xl_byte_cache #(
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 4,
  parameter int TAG_W      = 6,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int DATA_W = 8 * LINE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [OFF_W-1:0]  rd_off,
  output logic              rd_hit,
  output logic [7:0]        rd_byte
);
  logic [LINES-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic [7:0]        lane   [LINE_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n)     vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
    assign lane[b] = data_q[rd_idx][8*b +: 8];
  end

  assign rd_hit  = rd_en && vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_byte = rd_hit ? lane[rd_off] : 8'd0;
endmodule

// File: rtl/addr_xlate_probe.sv
module addr_xlate_probe #(
  parameter int VA_W       = 14,
  parameter int PA_W       = 12,
  parameter int PAGE_OFF_W = 6,
  parameter int TLB_SETS   = 4,
  parameter int TLB_WAYS   = 4,
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 4
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       req_valid,
  output logic                                       req_ready,
  input  logic [VA_W-1:0]                            req_vaddr,
  output logic                                       rsp_valid,
  input  logic                                       rsp_ready,
  output logic                                       rsp_tlb_hit,
  output logic                                       rsp_fault,
  output logic [PA_W-1:0]                            rsp_paddr,
  output logic                                       rsp_cache_hit,
  output logic [7:0]                                 rsp_byte,
  input  logic                                       cfg_en,
  input  logic [1:0]                                 cfg_kind,
  input  logic [VA_W-PAGE_OFF_W-1:0]                 cfg_addr,
  input  logic                                       cfg_valid,
  input  logic [VA_W-PAGE_OFF_W-$clog2(TLB_SETS)-1:0] cfg_tag,
  input  logic [8*LINE_BYTES-1:0]                    cfg_data
);
  import addr_xlate_pkg::*;

  localparam int VPN_W   = VA_W - PAGE_OFF_W;
  localparam int PPN_W   = PA_W - PAGE_OFF_W;
  localparam int SET_W   = $clog2(TLB_SETS);
  localparam int WAY_W   = $clog2(TLB_WAYS);
  localparam int TTAG_W  = VPN_W - SET_W;
  localparam int IDX_W   = $clog2(LINES);
  localparam int BOFF_W  = $clog2(LINE_BYTES);
  localparam int CTAG_W  = PA_W - IDX_W - BOFF_W;

  xl_state_e         state_q;
  logic [VA_W-1:0]   vaddr_q;
  logic [VPN_W-1:0]  vpn;
  logic              tlb_hit, pt_valid, c_hit, probe_en;
  logic [PPN_W-1:0]  tlb_ppn, pt_ppn, ppn_sel;
  logic [PA_W-1:0]   paddr;
  logic [7:0]        c_byte;

  assign vpn = vaddr_q[VA_W-1:PAGE_OFF_W];

  xl_tlb_array #(.SETS(TLB_SETS), .WAYS(TLB_WAYS), .TAG_W(TTAG_W), .PPN_W(PPN_W)) u_tlb (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_en && cfg_kind == CFG_TLB),
    .wr_set(cfg_addr[SET_W+WAY_W-1:WAY_W]), .wr_way(cfg_addr[WAY_W-1:0]),
    .wr_valid(cfg_valid), .wr_tag(cfg_tag), .wr_ppn(cfg_data[PPN_W-1:0]),
    .lk_set(vpn[SET_W-1:0]), .lk_tag(vpn[VPN_W-1:SET_W]),
    .lk_hit(tlb_hit), .lk_ppn(tlb_ppn)
  );

  xl_page_table #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_pt (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_en && cfg_kind == CFG_PT), .wr_vpn(cfg_addr),
    .wr_valid(cfg_valid), .wr_ppn(cfg_data[PPN_W-1:0]),
    .rd_vpn(vpn), .rd_valid(pt_valid), .rd_ppn(pt_ppn)
  );

  // walk cycle uses page-table mapping, lookup cycle uses buffer mapping
  assign ppn_sel  = (state_q == ST_WALK) ? pt_ppn : tlb_ppn;
  assign paddr    = {ppn_sel, vaddr_q[PAGE_OFF_W-1:0]};
  assign probe_en = (state_q == ST_LOOK && tlb_hit) || (state_q == ST_WALK && pt_valid);

  xl_byte_cache #(.LINES(LINES), .LINE_BYTES(LINE_BYTES), .TAG_W(CTAG_W)) u_cache (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_en && cfg_kind == CFG_LINE), .wr_idx(cfg_addr[IDX_W-1:0]),
    .wr_valid(cfg_valid), .wr_tag(CTAG_W'(cfg_tag)), .wr_data(cfg_data),
    .rd_en(probe_en),
    .rd_idx(paddr[BOFF_W+IDX_W-1:BOFF_W]), .rd_tag(paddr[PA_W-1:BOFF_W+IDX_W]),
    .rd_off(paddr[BOFF_W-1:0]),
    .rd_hit(c_hit), .rd_byte(c_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      vaddr_q       <= '0;
      rsp_tlb_hit   <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_cache_hit <= 1'b0;
      rsp_byte      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          vaddr_q <= req_vaddr;
          state_q <= ST_LOOK;
        end
        ST_LOOK: if (tlb_hit) begin
          rsp_tlb_hit   <= 1'b1;
          rsp_fault     <= 1'b0;
          rsp_paddr     <= paddr;
          rsp_cache_hit <= c_hit;
          rsp_byte      <= c_byte;
          state_q       <= ST_RESP;
        end else begin
          state_q       <= ST_WALK;
        end
        ST_WALK: begin
          rsp_tlb_hit   <= 1'b0;
          rsp_fault     <= !pt_valid;
          rsp_paddr     <= pt_valid ? paddr : '0;
          rsp_cache_hit <= c_hit;
          rsp_byte      <= c_byte;
          state_q       <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
endmodule

// File: rtl/addr_xlate_chk.sv
module addr_xlate_chk #(
  parameter int PA_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic            rsp_tlb_hit,
  input logic            rsp_fault,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_cache_hit,
  input logic [7:0]      rsp_byte
);
  // R7
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_byte)
      && $stable(rsp_fault) && $stable(rsp_tlb_hit) && $stable(rsp_cache_hit));

  // R6
  no_early_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !rsp_valid && !req_ready);

  // R3
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> !rsp_cache_hit && !rsp_tlb_hit && rsp_paddr == '0);

  // R5
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_cache_hit |-> rsp_byte == 8'd0);
endmodule

bind addr_xlate_probe addr_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tlb_hit(rsp_tlb_hit),
  .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_cache_hit(rsp_cache_hit),
  .rsp_byte(rsp_byte)
);

// File: tb/sim_addr_xlate_probe.sv
`timescale 1ns/1ps
module sim_addr_xlate_probe;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [13:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 0;
  logic        rsp_tlb_hit, rsp_fault, rsp_cache_hit;
  logic [11:0] rsp_paddr;
  logic [7:0]  rsp_byte;
  logic        cfg_en = 0;
  logic [1:0]  cfg_kind = '0;
  logic [7:0]  cfg_addr = '0;
  logic        cfg_valid = 0;
  logic [5:0]  cfg_tag = '0;
  logic [31:0] cfg_data = '0;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  addr_xlate_probe u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_tlb_hit(rsp_tlb_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .rsp_cache_hit(rsp_cache_hit), .rsp_byte(rsp_byte), .cfg_en(cfg_en),
    .cfg_kind(cfg_kind), .cfg_addr(cfg_addr), .cfg_valid(cfg_valid),
    .cfg_tag(cfg_tag), .cfg_data(cfg_data)
  );

  // shadow model of the three stores
  bit         m_tv [4][4];
  logic [5:0] m_tt [4][4];
  logic [5:0] m_tp [4][4];
  bit         m_pv [256];
  logic [5:0] m_pp [256];
  bit         m_cv [16];
  logic [5:0] m_ct [16];
  logic [31:0] m_cd [16];

  typedef struct {
    string      rq;
    bit         thit;
    bit         flt;
    logic [11:0] pa;
    bit         chit;
    logic [7:0] dbyte;
    int         lat;
    int         acc;
    int         hold;
  } item_t;

  item_t sb[$];

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] kind, input logic [7:0] a, input bit v,
                        input logic [5:0] tg, input logic [31:0] d);
    @(negedge clk);
    cfg_en = 1; cfg_kind = kind; cfg_addr = a; cfg_valid = v; cfg_tag = tg; cfg_data = d;
    @(negedge clk);
    cfg_en = 0;
    case (kind)
      2'd0: begin m_tv[a[3:2]][a[1:0]] = v; m_tt[a[3:2]][a[1:0]] = tg; m_tp[a[3:2]][a[1:0]] = d[5:0]; end
      2'd1: begin m_pv[a] = v; m_pp[a] = d[5:0]; end
      2'd2: begin m_cv[a[3:0]] = v; m_ct[a[3:0]] = tg; m_cd[a[3:0]] = d; end
      default: ;
    endcase
  endtask

  function automatic item_t predict(input logic [13:0] va);
    item_t it;
    logic [7:0] vpn;
    logic [5:0] ppn;
    bit found;
    vpn = va[13:6];
    found = 0; ppn = '0;
    for (int w = 3; w >= 0; w--)
      if (m_tv[vpn[1:0]][w] && m_tt[vpn[1:0]][w] == vpn[7:2]) begin found = 1; ppn = m_tp[vpn[1:0]][w]; end
    it.thit = found; it.lat = found ? 1 : 2; it.flt = 0;
    if (!found) begin
      if (m_pv[vpn]) ppn = m_pp[vpn];
      else it.flt = 1;
    end
    if (it.flt) begin
      it.pa = '0; it.chit = 0; it.dbyte = '0;
    end else begin
      it.pa = {ppn, va[5:0]};
      it.chit = m_cv[it.pa[5:2]] && m_ct[it.pa[5:2]] == it.pa[11:6];
      it.dbyte = it.chit ? m_cd[it.pa[5:2]][8*it.pa[1:0] +: 8] : 8'd0;
    end
    return it;
  endfunction

  task automatic send(input logic [13:0] va, input int hold, input string rq);
    item_t it;
    it = predict(va);
    it.rq = rq; it.hold = hold;
    @(negedge clk);
    req_valid = 1; req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    it.acc = cyc;
    sb.push_back(it);
    chk("R7", "req_ready_busy", req_ready, 0);
  endtask

  // monitor
  initial begin
    item_t cur;
    bit inflight = 0;
    int holdleft = 0;
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        if (!inflight) begin
          if (sb.size() == 0) begin
            chk("R7", "unexpected_rsp", 1, 0);
          end else begin
            cur = sb.pop_front();
            inflight = 1;
            holdleft = cur.hold;
            chk(cur.rq, "latency R6", cyc - cur.acc, cur.lat);
            chk(cur.rq, "tlb_hit", rsp_tlb_hit, cur.thit);
            chk(cur.rq, "fault", rsp_fault, cur.flt);
            chk(cur.rq, "paddr", rsp_paddr, cur.pa);
            chk(cur.rq, "cache_hit", rsp_cache_hit, cur.chit);
            chk(cur.rq, "byte", rsp_byte, cur.dbyte);
          end
        end else begin
          chk("R7", "held_paddr", rsp_paddr, cur.pa);
          chk("R7", "held_byte", rsp_byte, cur.dbyte);
          chk("R7", "held_fault", rsp_fault, cur.flt);
        end
        if (holdleft > 0) begin rsp_ready = 0; holdleft--; end
        else rsp_ready = 1;
      end else begin
        inflight = 0;
        rsp_ready = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9", "req_ready", req_ready, 1);
    chk("R9", "rsp_valid", rsp_valid, 0);
    // R9 empty stores -> fault
    send(14'h0123, 0, "R9");

    cfg_wr(2'd0, {2'd3, 2'd1}, 1, 6'h03, 32'h0D);   // vpn 0x0F
    cfg_wr(2'd0, {2'd0, 2'd2}, 1, 6'h02, 32'h11);   // vpn 0x08
    cfg_wr(2'd0, {2'd1, 2'd0}, 0, 6'h02, 32'h05);   // vpn 0x09 invalid way
    cfg_wr(2'd1, 8'h09, 1, 6'h00, 32'h2A);
    cfg_wr(2'd1, 8'h20, 1, 6'h00, 32'h0D);
    cfg_wr(2'd1, 8'h0F, 0, 6'h00, 32'h3F);
    cfg_wr(2'd2, 8'h05, 1, 6'h0D, 32'h44332211);
    cfg_wr(2'd2, 8'h03, 1, 6'h2A, 32'hDDCCBBAA);
    cfg_wr(2'd2, 8'h00, 1, 6'h11, 32'h87654321);
    cfg_wr(2'd2, 8'h07, 0, 6'h0D, 32'h00000099);

    send(14'h03D4, 0, "R1");  // buffer hit, lane 0
    send(14'h03D7, 2, "R4");  // lane 3, stalled response
    send(14'h024E, 0, "R2");  // walk via page table
    send(14'h024E, 3, "R8");  // still a miss
    send(14'h0040, 1, "R3");  // page fault
    send(14'h0802, 0, "R5");  // tag mismatch
    send(14'h0201, 0, "R1");  // other set
    send(14'h03DC, 0, "R5");  // invalid line

    cfg_wr(2'd3, 8'h05, 0, 6'h0D, 32'h0);           // R10 kind 3 ignored
    send(14'h03D4, 0, "R10");
    cfg_wr(2'd2, 8'h05, 1, 6'h0D, 32'hA5A5A5F0);    // R10 line rewrite
    send(14'h03D4, 0, "R10");
    cfg_wr(2'd0, {2'd3, 2'd1}, 0, 6'h03, 32'h0D);   // R10 way invalidated
    send(14'h03D4, 0, "R3");

    while (sb.size() != 0 || rsp_valid) @(negedge clk);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule